// File: doc/BRIEF.md
# Answer-to-Reset and Read Serializer

This block drives the serial data line of a synchronous memory card during its outgoing phases. The block runs on a fast system clock. It samples the card clock and the card reset as plain levels and acts on their falling edges. It drives a single open-drain enable. When that enable is high the line is pulled low. When it is low, an external pull-up holds the line high.

The block produces three outgoing streams, all least significant bit first:

- **Answer-to-reset.** After the card reset falls, it emits the first four bytes of main memory.
- **Main-memory read.** It emits every byte from a requested address up to the last byte of memory.
- **Protection read.** It emits the 32 protection flags.

After the last data bit of any stream, one more card-clock fall releases the line. The line then stays released until the next stream begins. Decoding commands and programming the memory are handled elsewhere. A neighbouring command decoder starts a read through a one-cycle request. Main memory is reached through a combinational byte read port, and the protection flags arrive as a parallel vector.

Top module: `atr_read_serializer`

## Requirements
- R1: After system reset `io_drive_low` is 0. Card-clock falls that arrive with no stream active leave it at 0.
- R2: While `card_rst` is 1, `io_drive_low` is 0 from the first system clock edge that samples it high. Any stream in progress is abandoned, and card-clock falls have no effect.
- R3: When `card_rst` falls, `io_drive_low` becomes the inverse of bit 0 of byte 0 on the next system clock edge.
- R4: During the answer-to-reset, the 31 card-clock falls after the reset fall emit bits 1 to 31 of the 32-bit string formed by bytes 0 to 3. Bit k is bit k mod 8 of byte k/8, and each one is shown as `io_drive_low` = inverse of the bit.
- R5: The 32nd card-clock fall after the reset fall releases the line (`io_drive_low` = 0). Later falls keep it released.
- R6: A main-memory read request (`cmd_kind` = 0, address N) makes fall number j (j = 1 to (256−N)·8) emit bit (j−1) mod 8 of byte N + (j−1)/8, as its inverse. The request also places N on `mem_addr` on the next system clock edge.
- R7: Fall number (256−N)·8+1 of a main-memory read releases the line. Later falls keep it released.
- R8: A protection read request (`cmd_kind` = 1; `cmd_addr` ignored) makes falls 1 to 32 emit `prot_bits[0]` to `prot_bits[31]` in that order. A set flag appears as `io_drive_low` = 1. Fall 33 releases the line.
- R9: A read request that arrives while a stream is running, or while `card_rst` is high, is ignored. The running stream continues unchanged.
- R10: `io_drive_low` changes only on the first system clock edge that samples a card-clock fall, a card-reset fall, or a high card reset. Card-clock rises never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| card_clk | input | 1 | Card clock level, sampled on clk |
| card_rst | input | 1 | Card reset level, active high, sampled on clk |
| cmd_go | input | 1 | One-cycle read request from the command decoder |
| cmd_kind | input | 1 | Read kind: 0 main memory, 1 protection flags |
| cmd_addr | input | ADDR_W | Start byte address of a main-memory read |
| mem_addr | output | ADDR_W | Byte address to the memory read port |
| mem_data | input | 8 | Byte returned combinationally for mem_addr |
| prot_bits | input | PROT_BITS | Protection flags, index 0 first |
| io_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
Every result is due one system clock after its trigger is first sampled. A card-clock fall, a card-reset fall or a high card reset updates `io_drive_low` on the first system clock edge that sees the new level. A read request shows its start address on `mem_addr` on the next edge. The scoreboard queues one expected line state for each card-clock or card-reset transition it drives. The monitor compares that state two falling system-clock edges after the transition, which is clear of the active edge and well before the next transition. After each card-clock rise the monitor checks the same value again, which confirms that rises leave the line alone.

// File: rtl/ser_atr_pkg.sv
package ser_atr_pkg;

  localparam int BYTE_BITS = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_BITS);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_STREAM = 2'd2
  } ser_state_e;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_PROT = 1'b1
  } ser_src_e;

endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  // Assert asynchronously, release through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/ser_line_edges.sv
module ser_line_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic card_clk,
  input  logic card_rst,
  output logic clk_fall,
  output logic rst_fall
);

  logic clk_q;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      clk_q <= card_clk;
      rst_q <= card_rst;
    end
  end

  // A fall is seen on the first edge that samples the low level.
  assign clk_fall = clk_q & ~card_clk;
  assign rst_fall = rst_q & ~card_rst;

endmodule

// File: rtl/ser_stream_seq.sv
module ser_stream_seq
  import ser_atr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ATR_BYTES = 4,
  parameter int PROT_BITS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          card_rst,
  input  logic                          clk_fall,
  input  logic                          rst_fall,
  input  logic                          cmd_go,
  input  logic                          cmd_kind,
  input  logic [ADDR_W-1:0]             cmd_addr,
  output logic                          emit,
  output logic                          release_io,
  output logic [ADDR_W+BIT_IDX_W-1:0]   ptr,
  output ser_src_e                      src,
  output logic                          busy
);

  localparam int PTR_W     = ADDR_W + BIT_IDX_W;
  localparam int CNT_W     = PTR_W + 1;
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int ATR_BITS  = ATR_BYTES * BYTE_BITS;

  ser_state_e        state_q, state_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  ser_src_e          src_q, src_d;

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    remain_d   = remain_q;
    src_d      = src_q;
    emit       = 1'b0;
    release_io = 1'b0;
    if (card_rst) begin
      // Card reset wins everywhere: park at the start of the reset dump.
      state_d    = ST_HOLD;
      ptr_d      = '0;
      remain_d   = CNT_W'(ATR_BITS);
      src_d      = SRC_MAIN;
      release_io = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_go) begin
            state_d = ST_STREAM;
            if (cmd_kind) begin
              src_d    = SRC_PROT;
              ptr_d    = '0;
              remain_d = CNT_W'(PROT_BITS);
            end else begin
              src_d    = SRC_MAIN;
              ptr_d    = {cmd_addr, {BIT_IDX_W{1'b0}}};
              remain_d = (CNT_W'(MEM_BYTES) - CNT_W'(cmd_addr)) << BIT_IDX_W;
            end
          end
        end
        ST_HOLD: begin
          // The reset fall itself carries the first bit out.
          if (rst_fall) begin
            emit     = 1'b1;
            ptr_d    = ptr_q + PTR_W'(1);
            remain_d = remain_q - CNT_W'(1);
            state_d  = ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (clk_fall) begin
            if (remain_q != '0) begin
              emit     = 1'b1;
              ptr_d    = ptr_q + PTR_W'(1);
              remain_d = remain_q - CNT_W'(1);
            end else begin
              release_io = 1'b1;
              state_d    = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      remain_q <= '0;
      src_q    <= SRC_MAIN;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      remain_q <= remain_d;
      src_q    <= src_d;
    end
  end

  assign ptr  = ptr_q;
  assign src  = src_q;
  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/ser_bit_pick.sv
module ser_bit_pick
  import ser_atr_pkg::*;
#(
  parameter int PROT_BITS = 32,
  parameter int PIDX_W    = (PROT_BITS > 1) ? $clog2(PROT_BITS) : 1
) (
  input  ser_src_e                 src,
  input  logic [BIT_IDX_W-1:0]     bit_idx,
  input  logic [PIDX_W-1:0]        prot_idx,
  input  logic [BYTE_BITS-1:0]     mem_data,
  input  logic [PROT_BITS-1:0]     prot_bits,
  output logic                     drive_low
);

  logic prot_sel;
  logic main_sel;

  generate
    if (PROT_BITS > 1) begin : g_prot_many
      assign prot_sel = prot_bits[prot_idx];
    end else begin : g_prot_one
      logic unused_idx;
      assign unused_idx = ^prot_idx;
      assign prot_sel   = prot_bits[0] | (unused_idx & 1'b0);
    end
  endgenerate

  assign main_sel = mem_data[bit_idx];

  // A set protection flag shows as a low line; a main bit drives low when 0.
  assign drive_low = (src == SRC_PROT) ? prot_sel : ~main_sel;

endmodule

// File: rtl/atr_read_serializer.sv
module atr_read_serializer
  import ser_atr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ATR_BYTES = 4,
  parameter int PROT_BITS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   card_clk,
  input  logic                   card_rst,
  input  logic                   cmd_go,
  input  logic                   cmd_kind,
  input  logic [ADDR_W-1:0]      cmd_addr,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [BYTE_BITS-1:0]   mem_data,
  input  logic [PROT_BITS-1:0]   prot_bits,
  output logic                   io_drive_low
);

  localparam int PTR_W  = ADDR_W + BIT_IDX_W;
  localparam int PIDX_W = (PROT_BITS > 1) ? $clog2(PROT_BITS) : 1;

  logic             rst_sn;
  logic             clk_fall;
  logic             rst_fall;
  logic             emit;
  logic             release_io;
  logic [PTR_W-1:0] ptr;
  ser_src_e         src;
  logic             busy;
  logic             pick_low;
  logic             io_en;
  logic             io_d;
  logic             io_q;
  logic [PIDX_W-1:0] prot_idx;

  ser_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  ser_line_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_sn),
    .card_clk (card_clk),
    .card_rst (card_rst),
    .clk_fall (clk_fall),
    .rst_fall (rst_fall)
  );

  ser_stream_seq #(
    .ADDR_W    (ADDR_W),
    .ATR_BYTES (ATR_BYTES),
    .PROT_BITS (PROT_BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .card_rst   (card_rst),
    .clk_fall   (clk_fall),
    .rst_fall   (rst_fall),
    .cmd_go     (cmd_go),
    .cmd_kind   (cmd_kind),
    .cmd_addr   (cmd_addr),
    .emit       (emit),
    .release_io (release_io),
    .ptr        (ptr),
    .src        (src),
    .busy       (busy)
  );

  assign prot_idx = ptr[PIDX_W-1:0];

  ser_bit_pick #(
    .PROT_BITS (PROT_BITS),
    .PIDX_W    (PIDX_W)
  ) u_pick (
    .src       (src),
    .bit_idx   (ptr[BIT_IDX_W-1:0]),
    .prot_idx  (prot_idx),
    .mem_data  (mem_data),
    .prot_bits (prot_bits),
    .drive_low (pick_low)
  );

  assign mem_addr = ptr[PTR_W-1:BIT_IDX_W];

  // Line register: loads a data bit on emit, drops the pull-down on release.
  assign io_en = emit | release_io;
  assign io_d  = emit ? pick_low : 1'b0;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      io_q <= 1'b0;
    end else if (io_en) begin
      io_q <= io_d;
    end
  end

  assign io_drive_low = io_q;

endmodule

// File: rtl/ser_atr_read_chk.sv
module ser_atr_read_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              card_clk,
  input logic              card_rst,
  input logic              cmd_go,
  input logic              cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              io_drive_low,
  input logic              busy
);

  logic ck_q;
  logic rs_q;
  logic ck_fall;
  logic rs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= 1'b0;
      rs_q <= 1'b0;
    end else begin
      ck_q <= card_clk;
      rs_q <= card_rst;
    end
  end

  assign ck_fall = ck_q & ~card_clk;
  assign rs_fall = rs_q & ~card_rst;

  // R1: with no stream active the line is released
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !io_drive_low);

  // R2: a high card reset releases the line on the next edge
  assert_reset_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> !io_drive_low);

  // R6: a main read request presents its start address
  assert_start_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_go && !cmd_kind && !card_rst) |=> (mem_addr == $past(cmd_addr)));

  // R9: a request during activity leaves the read position alone
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_go && !card_rst && !ck_fall && !rs_fall) |=> $stable(mem_addr));

  // R10: without a triggering event the line keeps its state
  assert_line_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_fall && !rs_fall && !card_rst) |=> $stable(io_drive_low));

endmodule

bind atr_read_serializer ser_atr_read_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .card_clk     (card_clk),
  .card_rst     (card_rst),
  .cmd_go       (cmd_go),
  .cmd_kind     (cmd_kind),
  .cmd_addr     (cmd_addr),
  .mem_addr     (mem_addr),
  .io_drive_low (io_drive_low),
  .busy         (busy)
);

// File: tb/atr_read_serializer_test.sv
`timescale 1ns/1ps
module atr_read_serializer_test;

  localparam int ADDR_W    = 8;
  localparam int PROT_BITS = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic                 card_clk;
  logic                 card_rst;
  logic                 cmd_go;
  logic                 cmd_kind;
  logic [ADDR_W-1:0]    cmd_addr;
  logic [ADDR_W-1:0]    mem_addr;
  logic [7:0]           mem_data;
  logic [PROT_BITS-1:0] prot_bits;
  logic                 io_drive_low;

  logic [7:0] mem [256];
  assign mem_data = mem[mem_addr];

  atr_read_serializer #(.ADDR_W(ADDR_W), .ATR_BYTES(4), .PROT_BITS(PROT_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_rst(card_rst),
    .cmd_go(cmd_go), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .mem_addr(mem_addr), .mem_data(mem_data), .prot_bits(prot_bits),
    .io_drive_low(io_drive_low)
  );

  typedef struct {
    logic  exp_low;
    string tag;
  } item_t;

  item_t sb[$];
  int    errors = 0;
  int    checks = 0;
  bit    done   = 1'b0;
  event  ev_chk;

  // Monitor: compares two falling system edges after each driven transition.
  initial begin
    forever begin
      item_t it;
      @(ev_chk);
      repeat (2) @(negedge clk);
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: no expected item, actual io_drive_low=%0b expected none", io_drive_low);
      end else begin
        it = sb.pop_front();
        if (io_drive_low !== it.exp_low) begin
          errors++;
          $display("FAIL %s: io_drive_low=%0b expected %0b", it.tag, io_drive_low, it.exp_low);
        end
      end
    end
  end

  function automatic logic main_low(int byte_a, int bit_b);
    return ~mem[byte_a][bit_b];
  endfunction

  task automatic expect_now(logic e, string tag);
    sb.push_back('{e, tag});
    ->ev_chk;
    repeat (4) @(negedge clk);
  endtask

  task automatic clk_pulse(logic e, string tag);
    @(negedge clk) card_clk = 1'b0;
    expect_now(e, tag);
    card_clk = 1'b1;
    expect_now(e, "R10");
  endtask

  task automatic rst_raise();
    @(negedge clk) card_rst = 1'b1;
    expect_now(1'b0, "R2");
  endtask

  task automatic rst_drop(logic e, string tag);
    @(negedge clk) card_rst = 1'b0;
    expect_now(e, tag);
  endtask

  task automatic issue(logic kind, int addr);
    @(negedge clk);
    cmd_go   = 1'b1;
    cmd_kind = kind;
    cmd_addr = ADDR_W'(addr);
    @(negedge clk);
    cmd_go = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic answer_to_reset(string first_tag);
    rst_drop(main_low(0, 0), first_tag);
    for (int i = 1; i < 32; i++) clk_pulse(main_low(i / 8, i % 8), "R4");
    clk_pulse(1'b0, "R5");
    clk_pulse(1'b0, "R5");
  endtask

  task automatic main_read(int n);
    issue(1'b0, n);
    for (int j = 0; j < (256 - n) * 8; j++) clk_pulse(main_low(n + j / 8, j % 8), "R6");
    clk_pulse(1'b0, "R7");
    clk_pulse(1'b0, "R7");
  endtask

  // Watchdog
  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not finished, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 73 + 29) ^ (i * 5));
    prot_bits = 32'hA5C3_0F96;
    rst_n     = 1'b0;
    card_clk  = 1'b1;
    card_rst  = 1'b0;
    cmd_go    = 1'b0;
    cmd_kind  = 1'b0;
    cmd_addr  = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state and idle clocks
    expect_now(1'b0, "R1");
    clk_pulse(1'b0, "R1");
    clk_pulse(1'b0, "R1");

    // R2, R3, R4, R5: answer-to-reset with a clock pulse while reset is high
    rst_raise();
    clk_pulse(1'b0, "R2");
    answer_to_reset("R3");

    // R6, R7: reads near the top, the last byte alone, and the full memory
    main_read(250);
    main_read(255);
    main_read(0);

    // R8: protection flags, address ignored
    issue(1'b1, 77);
    for (int i = 0; i < 32; i++) clk_pulse(prot_bits[i], "R8");
    clk_pulse(1'b0, "R8");
    clk_pulse(1'b0, "R8");

    // R9: request during a running read is ignored
    issue(1'b0, 252);
    for (int j = 0; j < 5; j++) clk_pulse(main_low(252 + j / 8, j % 8), "R6");
    issue(1'b1, 0);
    for (int j = 5; j < 32; j++) clk_pulse(main_low(252 + j / 8, j % 8), "R9");
    clk_pulse(1'b0, "R7");

    // R2, R9: reset aborts a read; a request during reset is ignored
    issue(1'b0, 200);
    for (int j = 0; j < 10; j++) clk_pulse(main_low(200 + j / 8, j % 8), "R6");
    rst_raise();
    clk_pulse(1'b0, "R2");
    issue(1'b0, 5);
    answer_to_reset("R9");

    wait (sb.size() == 0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule